// File: doc/BRIEF.md
# Store-Set Memory Dependence Predictor

This block decides, at fetch time, whether a load or store has to wait for an earlier store that is still in flight. The decision rests on store sets learned at run time. A PC-indexed set table maps each instruction to at most one set identifier. A per-set table holds the tag of the newest fetched store of that set that has not yet completed. A fetched load receives that tag as its dependency. A fetched store also receives the tag of its predecessor in the set, then takes that predecessor's place. Stores of one set therefore issue in order, and a load waits for all of them in turn.

Sets are learned from ordering violations. When a load that issued early is found to have read before a conflicting store, the pair of PCs is reported. Both PCs then join one set, and two existing sets are merged by always keeping the numerically smaller identifier. A free-running timer wipes both tables at a fixed period, which bounds aliasing and keeps merges from spreading without limit. Address comparison, scheduling and squash are handled outside the block.

Top module: `store_set_pred`

## Requirements
- R1: After reset, no fetch of any PC, load or store, reports a dependency.
- R2: A fetched load whose PC has a set identifier, and whose set holds a live store tag, reports `dep_valid`=1 with that tag in the same cycle.
- R3: A fetch whose PC has no set identifier, or whose set holds no live store, reports `dep_valid`=0. A store fetched without a set identifier changes no state.
- R4: A fetched store that has a set identifier reports the live tag of its set, if there is one, and its own tag is the live tag of the set from the next cycle on.
- R5: A violation in which neither PC has a set identifier gives both PCs the identifier `load_pc[2:0]`. The set table is indexed by `pc[3:0]`, so PCs that agree in those bits share an entry.
- R6: A violation in which exactly one of the two PCs has a set identifier gives that identifier to the other PC.
- R7: A violation in which both PCs have set identifiers gives both PCs the smaller of the two identifiers. Other members of the larger set keep their identifier.
- R8: A store completion clears its set's live entry only when the completing tag equals the recorded tag. A stale tag leaves the entry in place.
- R9: At the CLEAR_PERIOD-th rising edge after reset, and every CLEAR_PERIOD edges after that, every set-table entry and every live-store entry is invalidated. This takes priority over a fetch or violation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | A load or store is fetched this cycle |
| fetch_is_store | input | 1 | 1 = store, 0 = load |
| fetch_pc | input | 16 | PC of the fetched instruction |
| fetch_tag | input | 6 | In-flight tag of the fetched instruction |
| dep_valid | output | 1 | The fetched instruction must wait for `dep_tag` |
| dep_tag | output | 6 | Tag of the store to wait for |
| cmpl_valid | input | 1 | A store completes this cycle |
| cmpl_tag | input | 6 | Tag of the completing store |
| viol_valid | input | 1 | An ordering violation is reported |
| viol_load_pc | input | 16 | PC of the load that issued too early |
| viol_store_pc | input | 16 | PC of the store it conflicted with |

## Verification
The case that is hardest to reach from the ports is a merge of two sets that already exist. The set identifiers cannot be seen directly, so the stimulus first builds two disjoint sets through two fresh violations with chosen load PCs. It then reports a cross violation and fetches stores of both former sets. Which loads still see which store tags shows which identifier survived, and shows that the untouched member of the larger set stayed behind. The identifier derived from the load PC is made visible the same way: two unrelated violations whose load PCs agree in the low three bits end up sharing a live store.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    localparam int PC_W   = 16;
    localparam int IDX_W  = 4;
    localparam int SSID_W = 3;
    localparam int TAG_W  = 6;
    localparam int SSIT_N = 1 << IDX_W;
    localparam int SET_N  = 1 << SSID_W;

    typedef logic [SSID_W-1:0] ssid_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        logic  vld;
        ssid_t id;
    } ssit_ent_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
    } lfst_ent_t;

    typedef enum logic [1:0] {
        MRG_FRESH     = 2'd0,
        MRG_USE_STORE = 2'd1,
        MRG_USE_LOAD  = 2'd2,
        MRG_USE_MIN   = 2'd3
    } merge_kind_t;

    function automatic idx_t pc_index(input logic [PC_W-1:0] pc);
        return pc[IDX_W-1:0];
    endfunction

    function automatic ssid_t fresh_id(input logic [PC_W-1:0] pc);
        return pc[SSID_W-1:0];
    endfunction

    function automatic merge_kind_t merge_kind(input logic ld_vld, input logic st_vld);
        case ({ld_vld, st_vld})
            2'b00:   return MRG_FRESH;
            2'b01:   return MRG_USE_STORE;
            2'b10:   return MRG_USE_LOAD;
            default: return MRG_USE_MIN;
        endcase
    endfunction

    function automatic ssid_t id_min(input ssid_t a, input ssid_t b);
        return (a < b) ? a : b;
    endfunction
endpackage

// File: rtl/ssp_clr_timer.sv
module ssp_clr_timer #(
    parameter int PERIOD = 4096
) (
    input  logic clk,
    input  logic rst,
    output logic pulse
);
    localparam int CW = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt;

    assign pulse = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst)        cnt <= '0;
        else if (pulse) cnt <= '0;
        else            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ssp_ssit.sv
module ssp_ssit
    import ssp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic [PC_W-1:0] rd_pc,
    output ssit_ent_t       rd_ent,
    input  logic            viol_valid,
    input  logic [PC_W-1:0] viol_load_pc,
    input  logic [PC_W-1:0] viol_store_pc
);
    ssit_ent_t   tbl [SSIT_N];
    ssit_ent_t   ld_ent, st_ent;
    ssid_t       new_id;
    merge_kind_t kind;

    assign rd_ent = tbl[pc_index(rd_pc)];
    assign ld_ent = tbl[pc_index(viol_load_pc)];
    assign st_ent = tbl[pc_index(viol_store_pc)];
    assign kind   = merge_kind(ld_ent.vld, st_ent.vld);

    always_comb begin
        case (kind)
            MRG_FRESH:     new_id = fresh_id(viol_load_pc);
            MRG_USE_STORE: new_id = st_ent.id;
            MRG_USE_LOAD:  new_id = ld_ent.id;
            default:       new_id = id_min(ld_ent.id, st_ent.id);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < SSIT_N; i++) tbl[i] <= '0;
        end else if (viol_valid) begin
            tbl[pc_index(viol_load_pc)]  <= '{vld: 1'b1, id: new_id};
            tbl[pc_index(viol_store_pc)] <= '{vld: 1'b1, id: new_id};
        end
    end
endmodule

// File: rtl/ssp_lfst.sv
module ssp_lfst
    import ssp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  ssid_t     rd_id,
    output lfst_ent_t rd_ent,
    input  logic      wr_en,
    input  tag_t      wr_tag,
    input  logic      cmpl_valid,
    input  tag_t      cmpl_tag
);
    lfst_ent_t ent [SET_N];

    assign rd_ent = ent[rd_id];

    for (genvar k = 0; k < SET_N; k++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst || clr)
                ent[k] <= '0;
            else if (wr_en && rd_id == ssid_t'(k))
                ent[k] <= '{vld: 1'b1, tag: wr_tag};
            else if (cmpl_valid && ent[k].vld && ent[k].tag == cmpl_tag)
                ent[k].vld <= 1'b0;
        end
    end
endmodule

// File: rtl/store_set_pred.sv
module store_set_pred
    import ssp_pkg::*;
#(
    parameter int CLEAR_PERIOD = 4096
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fetch_valid,
    input  logic             fetch_is_store,
    input  logic [PC_W-1:0]  fetch_pc,
    input  logic [TAG_W-1:0] fetch_tag,
    output logic             dep_valid,
    output logic [TAG_W-1:0] dep_tag,
    input  logic             cmpl_valid,
    input  logic [TAG_W-1:0] cmpl_tag,
    input  logic             viol_valid,
    input  logic [PC_W-1:0]  viol_load_pc,
    input  logic [PC_W-1:0]  viol_store_pc
);
    ssit_ent_t fetch_set;
    lfst_ent_t live;
    logic      ssit_hit;
    logic      clr_pulse;
    logic      store_claim;

    ssp_clr_timer #(.PERIOD(CLEAR_PERIOD)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .pulse (clr_pulse)
    );

    ssp_ssit u_ssit (
        .clk           (clk),
        .rst           (rst),
        .clr           (clr_pulse),
        .rd_pc         (fetch_pc),
        .rd_ent        (fetch_set),
        .viol_valid    (viol_valid),
        .viol_load_pc  (viol_load_pc),
        .viol_store_pc (viol_store_pc)
    );

    assign ssit_hit    = fetch_valid && fetch_set.vld;
    assign store_claim = ssit_hit && fetch_is_store;

    ssp_lfst u_lfst (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr_pulse),
        .rd_id      (fetch_set.id),
        .rd_ent     (live),
        .wr_en      (store_claim),
        .wr_tag     (fetch_tag),
        .cmpl_valid (cmpl_valid),
        .cmpl_tag   (cmpl_tag)
    );

    assign dep_valid = ssit_hit && live.vld;
    assign dep_tag   = live.tag;
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker
    import ssp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             fetch_valid,
    input logic             fetch_is_store,
    input logic [PC_W-1:0]  fetch_pc,
    input logic [TAG_W-1:0] fetch_tag,
    input logic             viol_valid,
    input logic             dep_valid,
    input logic [TAG_W-1:0] dep_tag,
    input logic             ssit_hit,
    input logic             clr_pulse
);
    // R1: tables are empty in the first cycle after reset
    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !dep_valid);

    // R3: no dependency without a fetch
    a_r3_no_dep_idle: assert property (@(posedge clk) disable iff (rst)
        !fetch_valid |-> !dep_valid);

    // R2: a dependency needs a set identifier
    a_r2_dep_needs_set: assert property (@(posedge clk) disable iff (rst)
        dep_valid |-> ssit_hit);

    // R4: a claiming store is the live tag seen by the next fetch of the same PC
    a_r4_store_claims: assert property (@(posedge clk) disable iff (rst)
        ($past(fetch_valid && fetch_is_store && ssit_hit && !clr_pulse && !viol_valid)
         && !$past(rst) && fetch_valid && fetch_pc == $past(fetch_pc))
        |-> (dep_valid && dep_tag == $past(fetch_tag)));

    // R9: nothing survives a periodic clear
    a_r9_clear_empties: assert property (@(posedge clk) disable iff (rst)
        ($past(clr_pulse) && !$past(rst)) |-> !dep_valid);
endmodule

bind store_set_pred ssp_checker u_chk (
    .clk            (clk),
    .rst            (rst),
    .fetch_valid    (fetch_valid),
    .fetch_is_store (fetch_is_store),
    .fetch_pc       (fetch_pc),
    .fetch_tag      (fetch_tag),
    .viol_valid     (viol_valid),
    .dep_valid      (dep_valid),
    .dep_tag        (dep_tag),
    .ssit_hit       (ssit_hit),
    .clr_pulse      (clr_pulse)
);

// File: tb/test_store_set_pred.sv
module test_store_set_pred;
    localparam int CLK_PERIOD = 10;
    localparam int PERIOD     = 600;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_valid = 1'b0, fetch_is_store = 1'b0;
    logic [15:0] fetch_pc = '0;
    logic [5:0]  fetch_tag = '0;
    logic        dep_valid;
    logic [5:0]  dep_tag;
    logic        cmpl_valid = 1'b0;
    logic [5:0]  cmpl_tag = '0;
    logic        viol_valid = 1'b0;
    logic [15:0] viol_load_pc = '0, viol_store_pc = '0;

    int tests = 0;
    int fails = 0;
    int edges = 0;

    store_set_pred #(.CLEAR_PERIOD(PERIOD)) i_store_set_pred (
        .clk(clk), .rst(rst),
        .fetch_valid(fetch_valid), .fetch_is_store(fetch_is_store),
        .fetch_pc(fetch_pc), .fetch_tag(fetch_tag),
        .dep_valid(dep_valid), .dep_tag(dep_tag),
        .cmpl_valid(cmpl_valid), .cmpl_tag(cmpl_tag),
        .viol_valid(viol_valid), .viol_load_pc(viol_load_pc),
        .viol_store_pc(viol_store_pc)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) edges <= 0;
        else     edges <= edges + 1;
    end

    task automatic check_dep(input logic ev, input logic [5:0] et, input string req);
        tests++;
        if (dep_valid !== ev || (ev && dep_tag !== et)) begin
            fails++;
            $display("FAIL %s: dep_valid=%0b dep_tag=%0d expected dep_valid=%0b dep_tag=%0d",
                     req, dep_valid, dep_tag, ev, et);
        end
    endtask

    // called just after a falling edge; returns just after the next falling edge
    task automatic fetch(input int pc, input logic st, input int tag,
                         input logic ev, input int et, input string req);
        fetch_valid = 1'b1; fetch_is_store = st;
        fetch_pc = 16'(pc); fetch_tag = 6'(tag);
        #1 check_dep(ev, 6'(et), req);
        @(negedge clk);
        fetch_valid = 1'b0; fetch_is_store = 1'b0;
    endtask

    task automatic viol(input int lpc, input int spc);
        viol_valid = 1'b1; viol_load_pc = 16'(lpc); viol_store_pc = 16'(spc);
        @(negedge clk);
        viol_valid = 1'b0;
    endtask

    task automatic complete(input int tag);
        cmpl_valid = 1'b1; cmpl_tag = 6'(tag);
        @(negedge clk);
        cmpl_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_reset();

        // R1: every PC, both kinds, reports nothing after reset
        for (int p = 0; p < 16; p++) begin
            fetch(p, 1'b1, p, 1'b0, 0, "R1 store after reset");
            fetch(p, 1'b0, p, 1'b0, 0, "R1 load after reset");
        end

        // R5/R2/R3 sweep: fresh pair per load PC
        for (int i = 0; i < 16; i++) begin
            do_reset();
            viol(i, (i + 3) % 16);
            fetch((i + 3) % 16, 1'b1, i + 1, 1'b0, 0, "R3 first store empty set");
            fetch(i, 1'b0, 0, 1'b1, i + 1, "R2 load waits for store");
            fetch((i + 8) % 16, 1'b0, 0, 1'b0, 0, "R3 unlearned load");
        end

        // R5: identifier comes from load_pc[2:0]
        do_reset();
        viol(1, 4);
        viol(9, 6);
        fetch(4, 1'b1, 7, 1'b0, 0, "R5 store set 1");
        fetch(9, 1'b0, 0, 1'b1, 7, "R5 shared identifier");
        // R5: PC aliasing on pc[3:0]
        fetch(16'h0019, 1'b0, 0, 1'b1, 7, "R5 aliased PC");

        // R6/R4 chaining
        do_reset();
        viol(2, 5);
        viol(2, 7);
        fetch(5, 1'b1, 10, 1'b0, 0, "R4 first store");
        fetch(7, 1'b1, 11, 1'b1, 10, "R4 store waits for store / R6");
        fetch(2, 1'b0, 0, 1'b1, 11, "R4 newest store");
        // R8
        complete(10);
        fetch(2, 1'b0, 0, 1'b1, 11, "R8 stale completion ignored");
        complete(11);
        fetch(2, 1'b0, 0, 1'b0, 0, "R8 matching completion");
        // R6: load joins store's set
        viol(3, 7);
        fetch(7, 1'b1, 20, 1'b0, 0, "R6 store");
        fetch(3, 1'b0, 0, 1'b1, 20, "R6 load took store id");

        // R7: store side smaller
        do_reset();
        viol(6, 12);
        viol(3, 13);
        viol(6, 13);
        fetch(12, 1'b1, 30, 1'b0, 0, "R7 store left behind");
        fetch(6, 1'b0, 0, 1'b0, 0, "R7 load left larger set");
        fetch(13, 1'b1, 31, 1'b0, 0, "R7 merged store");
        fetch(6, 1'b0, 0, 1'b1, 31, "R7 load in smaller set");
        fetch(3, 1'b0, 0, 1'b1, 31, "R7 other load in smaller set");

        // R7: load side smaller
        do_reset();
        viol(1, 10);
        viol(5, 11);
        viol(1, 11);
        fetch(11, 1'b1, 40, 1'b0, 0, "R7 store moved");
        fetch(1, 1'b0, 0, 1'b1, 40, "R7 load keeps smaller id");
        fetch(5, 1'b0, 0, 1'b0, 0, "R7 old load stays");

        // R9: periodic clear
        do_reset();
        viol(2, 9);
        fetch(9, 1'b1, 50, 1'b0, 0, "R9 setup store");
        while (edges != PERIOD - 1) @(negedge clk);
        fetch_valid = 1'b1; fetch_is_store = 1'b0; fetch_pc = 16'd2;
        #1 check_dep(1'b1, 6'd50, "R9 state kept before clear");
        @(negedge clk);
        #1 check_dep(1'b0, 6'd0, "R9 state gone after clear");
        fetch_valid = 1'b0;
        @(negedge clk);
        fetch(9, 1'b1, 51, 1'b0, 0, "R9 store after clear");
        fetch(2, 1'b0, 0, 1'b0, 0, "R9 set table cleared");

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule